// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes handed to it into asynchronous serial frames on a single output line. Each byte enters through a one-entry holding register and then moves to a shift register that drives the line. The frame is a low start bit, seven or eight data bits, an optional parity bit and one or two high stop bits. The line rests high between frames. A control byte chooses the character length, parity mode, stop-bit count and bit order, and also holds a power enable and a transmit enable. A 16-bit divisor sets the bit period to twice its value in input clock cycles.

Bytes enter on a valid/ready handshake. A byte is taken on a rising clock edge where `tx_valid_i` and `tx_ready_o` are both high. `tx_ready_o` is high only when power and transmit are both enabled and the holding register is empty. A byte offered at any other time is not taken, and the source has to keep `tx_valid_i` and `tx_data_i` steady until the handshake completes. A second byte can wait in the holding register while the first is still shifting, so frames can follow each other with no idle gap. `busy_o` reports that a byte is held or shifting. `done_irq_o` pulses once at the end of each frame. The control byte is sampled when a frame begins, and changes made during a frame take effect from the next frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever nothing is held or shifting, `txd_o` is high and `busy_o` is low.
- R2: Each frame is a low start bit, then the data bits, then the parity bit if one is enabled, then high stop bits. Every bit lasts exactly 2×D clock cycles, where D is the effective divisor. Bit 0 starts on the clock edge after the byte moves from the holding register into the shifter.
- R3: Control bit 4 selects the bit order. When it is 1 the data goes out least significant bit first; when it is 0 it goes out most significant bit first.
- R4: Control bit 1 selects the character length: 1 sends 8 data bits and 0 sends 7. In 7-bit mode, bit 7 of the byte has no effect on the data bits or on the parity bit.
- R5: Control bits 3:2 select parity: 00 sends no parity bit, 01 sends a parity bit that is always 0, 10 sends odd parity (the data plus the parity bit hold an odd number of ones), and 11 sends even parity.
- R6: Control bit 0 selects the stop bits: 1 sends two stop bits and 0 sends one.
- R7: A divisor value below 4 is treated as 4. Values from 4 to 65535 are used as given.
- R8: `busy_o` rises on the edge after a byte is accepted and stays high until the last stop bit ends. It is low on the following cycle unless another byte is pending.
- R9: `done_irq_o` is high for exactly one cycle after each frame's last stop bit, once per frame.
- R10: `tx_ready_o` is low while control bit 7 (power) or control bit 6 (transmit enable) is 0. A byte offered then is not taken and nothing is sent. Control bit 5 has no effect on the transmitter.
- R11: When control bit 7 is 0 on a clock edge, everything is cleared on that edge: the held byte and any frame in progress are dropped, `txd_o` is high and `busy_o` is low afterwards, and no interrupt pulse follows.
- R12: The control byte in force when a frame starts decides that whole frame's format, even if the control byte changes during the frame.
- R13: A byte accepted while a frame is shifting begins with its start bit in the cycle right after the previous frame's last stop bit.

Parameter `DIV_W` sets the width of `divisor_i`. Parameter `MIN_DIV` sets the lower clamp of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 8 | Control byte: [7] power, [6] transmit enable, [5] no effect, [4] LSB first, [3:2] parity mode, [1] 8-bit, [0] two stop bits |
| divisor_i | input | 16 | Bit period divisor; each bit lasts twice this many cycles |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte can be taken this cycle |
| busy_o | output | 1 | A byte is held or shifting |
| done_irq_o | output | 1 | One-cycle pulse at the end of each frame |
| txd_o | output | 1 | Serial line, high when idle |

## Verification
A wrong bit count or shift state shows on `txd_o` within the frame where it occurs. The frame length, the parity bit or the position of a data bit comes out wrong at a mid-bit sample, at most one bit period (2×D cycles) after the fault. A wrong baud counter moves the mid-bit samples off, and the error grows with every bit, so at the minimum divisor it shows within a few bits. A holding register or busy flag that fails to clear shows at the ports in the first cycle after the frame: `busy_o` stays high, an interrupt is missed or repeated, or the next frame's start bit is lost or comes too early.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;            // start + data + parity + two stops
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_e;

  // field order matches control byte bit positions 7..0
  typedef struct packed {
    logic pwr;
    logic txe;
    logic rx_unused;
    logic lsb_first;
    par_e par;
    logic eight;
    logic two_stop;
  } ctrl_t;
endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] eff_div;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    eff_div = (div_i < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_i;
    limit   = {eff_div, 1'b0} - CNT_W'(1);
  end

  assign tick_o = run_i && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear_i || restart_i) begin
      cnt <= '0;
    end else if (run_i) begin
      cnt <= tick_o ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
(
  input  logic [DATA_W-1:0]  data_i,
  input  ctrl_t              cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] ordered;
  logic              par_bit;
  int                nbits;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == DATA_W - 1) begin : g_top
      assign masked[i]  = data_i[i] & cfg_i.eight;
      assign ordered[i] = cfg_i.lsb_first ? masked[i]
                        : (cfg_i.eight ? masked[0] : 1'b0);
    end else begin : g_low
      assign masked[i]  = data_i[i];
      assign ordered[i] = cfg_i.lsb_first ? masked[i]
                        : (cfg_i.eight ? masked[DATA_W-1-i] : masked[DATA_W-2-i]);
    end
  end

  always_comb begin
    case (cfg_i.par)
      PAR_ZERO: par_bit = 1'b0;
      PAR_ODD:  par_bit = ~(^masked);
      PAR_EVEN: par_bit = ^masked;
      default:  par_bit = 1'b1;
    endcase
  end

  always_comb begin
    nbits   = cfg_i.eight ? DATA_W : DATA_W - 1;
    frame_o = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) frame_o[1+i] = ordered[i];
    end
    for (int j = 1; j < FRAME_W; j++) begin
      if ((j == 1 + nbits) && (cfg_i.par != PAR_NONE)) frame_o[j] = par_bit;
    end
    len_o = LEN_W'(2 + nbits) + LEN_W'(cfg_i.par != PAR_NONE) + LEN_W'(cfg_i.two_stop);
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               tick_i,
  output logic               txd_o,
  output logic               active_o,
  output logic               free_o,
  output logic               done_o
);
  logic [FRAME_W-1:0] sr;
  logic [LEN_W-1:0]   left;
  logic               last;

  assign last     = active_o && tick_i && (left == LEN_W'(1));
  assign free_o   = !active_o || last;
  assign txd_o    = active_o ? sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '1;
      left     <= '0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else if (clear_i) begin
      sr       <= '1;
      left     <= '0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last;
      if (load_i) begin
        sr       <= frame_i;
        left     <= len_i;
        active_o <= 1'b1;
      end else if (active_o && tick_i) begin
        sr   <= {1'b1, sr[FRAME_W-1:1]};
        left <= left - LEN_W'(1);
        if (left == LEN_W'(1)) active_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import utx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ctrl_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              busy_o,
  output logic              done_irq_o,
  output logic              txd_o
);
  ctrl_t              cfg;
  logic               clear;
  logic               accept;
  logic               load;
  logic               hold_full;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               tick;
  logic               active;
  logic               free;

  assign cfg        = ctrl_t'(ctrl_i);
  assign clear      = !cfg.pwr;
  assign tx_ready_o = cfg.pwr && cfg.txe && !hold_full;
  assign accept     = tx_valid_i && tx_ready_o;
  assign load       = hold_full && free && cfg.pwr;
  assign busy_o     = hold_full || active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (clear) begin
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= tx_data_i;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  utx_framer u_framer (
    .data_i  (hold_data),
    .cfg_i   (cfg),
    .frame_o (frame),
    .len_o   (len)
  );

  utx_baud #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear),
    .restart_i (load),
    .run_i     (active),
    .div_i     (divisor_i),
    .tick_o    (tick)
  );

  utx_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear),
    .load_i   (load),
    .frame_i  (frame),
    .len_i    (len),
    .tick_i   (tick),
    .txd_o    (txd_o),
    .active_o (active),
    .free_o   (free),
    .done_o   (done_irq_o)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       busy_o,
  input logic       done_irq_o,
  input logic       txd_o
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> txd_o); // R1

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd_o) |-> busy_o); // R2

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o && ctrl_i[7]) |=> busy_o); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |=> !done_irq_o); // R9

  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq_o) |-> $past(busy_o)); // R9

  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_i[7] && ctrl_i[6]) |-> !tx_ready_o); // R10

  AST_POWER_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[7] |=> (txd_o && !busy_o && !done_irq_o)); // R11
endmodule

bind uart_frame_tx utx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_i     (ctrl_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .busy_o     (busy_o),
  .done_irq_o (done_irq_o),
  .txd_o      (txd_o)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctrl = 8'h00;
  logic [15:0] div = 16'd4;
  logic [7:0]  data = 8'h00;
  logic        valid = 1'b0;
  logic        ready, busy, irq, txd;
  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;

  always #5 clk = ~clk;

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .divisor_i(div),
    .tx_data_i(data), .tx_valid_i(valid), .tx_ready_o(ready),
    .busy_o(busy), .done_irq_o(irq), .txd_o(txd)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] c);
    return 1 + (c[1] ? 8 : 7) + ((c[3:2] != 2'b00) ? 1 : 0) + 1 + int'(c[0]);
  endfunction

  function automatic logic [11:0] exp_frame(input logic [7:0] c, input logic [7:0] d);
    int n = c[1] ? 8 : 7;
    logic [7:0] m = c[1] ? d : {1'b0, d[6:0]};
    int ones = $countones(m);
    logic [11:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) f[1+i] = c[4] ? m[i] : m[n-1-i];
    if (c[3:2] == 2'b01) f[1+n] = 1'b0;
    if (c[3:2] == 2'b10) f[1+n] = ((ones % 2) == 0);
    if (c[3:2] == 2'b11) f[1+n] = ((ones % 2) == 1);
    return f;
  endfunction

  task automatic send(input logic [7:0] b);
    int t = 0;
    while (!ready && t < 5000) begin @(negedge clk); t++; end
    valid = 1'b1;
    data  = b;
    @(negedge clk);
    valid = 1'b0;
  endtask

  // entry with wait_start=0 must be at the negedge of cycle 0 of bit 0
  task automatic capture(input bit wait_start, input int bits, input int half,
                         output logic [11:0] got, output bit busy_ok);
    int t = 0;
    got = '1;
    busy_ok = 1'b1;
    if (wait_start)
      while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    for (int k = 0; k < bits; k++) begin
      repeat (half) @(negedge clk);
      got[k] = txd;
      if (busy !== 1'b1) busy_ok = 1'b0;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic [7:0] c, input logic [7:0] d, input int half);
    logic [11:0] got;
    bit bok;
    ctrl = c;
    irq_cnt = 0;
    fork
      send(d);
      capture(1'b1, exp_len(c), half, got, bok);
    join
    check(got == exp_frame(c, d), "R2 R3 R4 R5 R6 R7 frame bits", int'(got), int'(exp_frame(c, d)));
    check(bok && busy == 1'b0, "R8 busy high in frame, low after", int'(busy), 0);
    repeat (3) @(negedge clk);
    check(irq_cnt == 1, "R9 one interrupt per frame", irq_cnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] vals [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h80};
    logic [11:0] g1, g2;
    bit b1, b2;
    int bad;

    repeat (3) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0 && ready == 1'b0, "R1 reset state", int'({txd, busy, ready}), 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R1 idle after reset", int'({txd, busy}), 2'b10);

    // sweep every format at the minimum divisor
    for (int dir = 0; dir < 2; dir++)
      for (int par = 0; par < 4; par++)
        for (int ln = 0; ln < 2; ln++)
          for (int st = 0; st < 2; st++)
            for (int v = 0; v < 4; v++)
              run_frame({2'b11, 1'b0, 1'(dir), 2'(par), 1'(ln), 1'(st)}, vals[v], 4);

    // R7: clamp below minimum, plain value above it
    div = 16'd1;
    run_frame(8'hDE, 8'h5A, 4);
    div = 16'd5;
    run_frame(8'hCB, 8'h96, 5);
    div = 16'd4;

    // R13: back-to-back frames without gap
    ctrl = 8'hD2;
    irq_cnt = 0;
    fork
      begin send(8'h81); send(8'h7E); end
      begin
        capture(1'b1, exp_len(8'hD2), 4, g1, b1);
        capture(1'b0, exp_len(8'hD2), 4, g2, b2);
      end
    join
    check(g1 == exp_frame(8'hD2, 8'h81), "R13 first frame", int'(g1), int'(exp_frame(8'hD2, 8'h81)));
    check(g2 == exp_frame(8'hD2, 8'h7E), "R13 second frame contiguous", int'(g2), int'(exp_frame(8'hD2, 8'h7E)));
    check(b1 && b2, "R8 busy across both frames", int'({b1, b2}), 3);
    repeat (3) @(negedge clk);
    check(irq_cnt == 2, "R9 two interrupts", irq_cnt, 2);

    // R12: control change during frame does not alter it
    ctrl = 8'hCE;
    fork
      begin send(8'h3B); repeat (30) @(negedge clk); ctrl = 8'hC3; end
      capture(1'b1, exp_len(8'hCE), 4, g1, b1);
    join
    check(g1 == exp_frame(8'hCE, 8'h3B), "R12 format sampled at frame start", int'(g1), int'(exp_frame(8'hCE, 8'h3B)));
    repeat (4) @(negedge clk);

    // R10: no transmit enable, then no power; control bit 5 set throughout
    foreach (vals[q]) begin end
    for (int m = 0; m < 2; m++) begin
      ctrl = (m == 0) ? 8'hA2 : 8'h62;
      irq_cnt = 0;
      valid = 1'b1;
      data = 8'h00;
      bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (ready !== 1'b0 || txd !== 1'b1 || busy !== 1'b0) bad++;
      end
      valid = 1'b0;
      check(bad == 0, "R10 offer refused while disabled", bad, 0);
      ctrl = 8'hE2;
      repeat (5) @(negedge clk);
      check(busy == 1'b0 && txd == 1'b1 && irq_cnt == 0, "R10 nothing queued by refused offer",
            int'({busy, txd}), 2'b01);
    end

    // R11: power off mid-frame
    ctrl = 8'hC2;
    irq_cnt = 0;
    send(8'h00);
    repeat (25) @(negedge clk);
    check(busy == 1'b1 && txd == 1'b0, "R11 frame in progress", int'({busy, txd}), 2'b10);
    ctrl = 8'h02;
    @(negedge clk);
    check(busy == 1'b0 && txd == 1'b1, "R11 cleared on power off", int'({busy, txd}), 2'b01);
    repeat (30) @(negedge clk);
    check(irq_cnt == 0 && txd == 1'b1, "R11 no interrupt after power off", irq_cnt, 0);
    run_frame(8'hD3, 8'hC4, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule